// File: doc/BRIEF.md
# Receive Error Status and Interrupt Cause Unit

This block keeps the receive-side status of an asynchronous serial port. The receiver reports each completed character with a one-cycle pulse. Three error qualifiers travel with that pulse: parity, framing and overrun. The block holds each error in a sticky flag. A flag is latched only when its own check-enable bit in the control register is 1 and the receiver is enabled. Software reads the flags from a read-only state register.

Flags are not cleared by reading them, and not by writing the state register. They are cleared, and the receiver is switched on or off, only through a write-only strobe register. That register has a separate set bit or clear bit for each function.

The block also holds an interrupt enable register and an interrupt cause register for the transmit, receive and error sources. Cause bits are cleared by writing 1 to them. The block drives one interrupt line per source, plus a transmit-buffer line that follows a level from the transmit side.

Register access is a single-cycle write port with a combinational read. Reads and writes share one address bus. Register byte offsets are: control 0x00, state 0x04, strobe 0x08, interrupt enable 0x0C, interrupt cause 0x10.

Top module: `rxerr_status`

## Requirements
- R1: After reset, these all read 0: control, state, interrupt enable and interrupt cause. `rxEnable` and all four interrupt outputs are also 0.
- R2: The state register (0x04) holds the receiver enable at bit 0, the parity error flag at bit 16, the framing error flag at bit 17 and the overrun flag at bit 19. All other bits read 0.
- R3: The control register (0x00) stores framing check enable at bit 17, overrun check enable at bit 19 and parity check enable at bit 20, and reads them back. An error qualifier sets its flag only when its check enable is 1.
- R4: A receive-complete pulse that arrives while the receiver enable is 0 is discarded. It sets no error flag and no receive cause.
- R5: The strobe register (0x08) is write-only and reads 0. Bit 0 clears the receiver enable and bit 1 sets it. When both bits are written together, set wins.
- R6: Strobe bit 2 clears the parity flag, bit 3 clears the framing flag and bit 5 clears the overrun flag. Apart from these, a flag stays set. A write to the state register has no effect.
- R7: If an error event and the clear strobe for the same flag land in the same cycle, the flag ends up set.
- R8: An overrun is reported together with the character it arrives with. That character still counts as received: the overrun flag and the receive cause are set in the same cycle.
- R9: The cause register (0x10) sets bit 0 on a transmit-done pulse, bit 1 on each accepted receive-complete pulse, and bit 2 when any error flag is latched. Writing 1 to a bit clears it. A new event in the same cycle as the clear wins.
- R10: The interrupt enable register (0x0C) holds transmit at bit 0, receive at bit 1, error at bit 2 and transmit buffer at bit 3. The transmit and receive lines are their cause bit ANDed with their enable. The error line is the OR of the three error flags ANDed with enable bit 2. The transmit-buffer line is the transmit-space level ANDed with enable bit 3.
- R11: A register write takes effect from the clock edge that ends the write cycle, and is visible on the read path one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Write strobe for the register port |
| regAddr | input | ADDR_W | Byte offset, used for both read and write |
| regWdata | input | DATA_W | Write data |
| regRdata | output | DATA_W | Read data of the addressed register (combinational) |
| rxDone | input | 1 | One-cycle pulse: a character has been received |
| rxParityErr | input | 1 | Parity error qualifier for `rxDone` |
| rxFrameErr | input | 1 | Framing error qualifier for `rxDone` |
| rxOverrun | input | 1 | Overrun qualifier for `rxDone` |
| txDone | input | 1 | One-cycle pulse: a character has been sent |
| txSpace | input | 1 | Level: transmit buffer has room |
| rxEnable | output | 1 | Receiver enable flag |
| irqTx | output | 1 | Transmit interrupt |
| irqRx | output | 1 | Receive interrupt |
| irqErr | output | 1 | Error interrupt |
| irqTxBuf | output | 1 | Transmit buffer interrupt |

## Verification
The error latching is exercised with single-error characters of each kind, with a framing error and an overrun stacked, and with all three at once while the receiver is off. Telling these patterns apart shows that each flag sits at its own bit and is cleared only by its own strobe bit. Disabling two of the three check enables and sending those two errors shows that gating is per flag and that the character still raises the receive cause. Error events are also driven in the same cycle as the matching clear strobe or cause write. These collisions separate a set-wins design from a clear-wins one. The receiver enable is driven with set only, clear only and both at once.

// File: rtl/rxerr_pkg.sv
package rxerr_pkg;

  // register byte offsets
  localparam int OFS_CTRL   = 'h00;
  localparam int OFS_STATE  = 'h04;
  localparam int OFS_STROBE = 'h08;
  localparam int OFS_IEN    = 'h0C;
  localparam int OFS_CAUSE  = 'h10;

  // state register bits
  localparam int ST_REN_BIT = 0;
  localparam int ST_PE_BIT  = 16;
  localparam int ST_FE_BIT  = 17;
  localparam int ST_ROE_BIT = 19;

  // control register check enables
  localparam int CT_FE_BIT  = 17;
  localparam int CT_ROE_BIT = 19;
  localparam int CT_PE_BIT  = 20;

  // strobe register bits
  localparam int SB_CLR_REN = 0;
  localparam int SB_SET_REN = 1;
  localparam int SB_CLR_PE  = 2;
  localparam int SB_CLR_FE  = 3;
  localparam int SB_CLR_ROE = 5;

  // interrupt sources
  localparam int IRQ_TX    = 0;
  localparam int IRQ_RX    = 1;
  localparam int IRQ_ERR   = 2;
  localparam int IRQ_TXBUF = 3;
  localparam int NUM_CAUSE = 3;
  localparam int NUM_IEN   = 4;

  // error flag vector order
  localparam int ERR_PE  = 0;
  localparam int ERR_FE  = 1;
  localparam int ERR_ROE = 2;
  localparam int NUM_ERR = 3;

  typedef enum logic [2:0] {
    SEL_CTRL,
    SEL_STATE,
    SEL_STROBE,
    SEL_IEN,
    SEL_CAUSE,
    SEL_NONE
  } regSel_e;

  typedef struct packed {
    logic                 ctrlWr;
    logic [NUM_ERR-1:0]   ctrlVal;   // check enables, ERR_* order
    logic                 ienWr;
    logic [NUM_IEN-1:0]   ienVal;
    logic [NUM_CAUSE-1:0] causeClr;
    logic                 setRen;
    logic                 clrRen;
    logic [NUM_ERR-1:0]   errClr;    // ERR_* order
  } strobe_t;

endpackage

// File: rtl/rxerr_ctrl.sv
module rxerr_ctrl
  import rxerr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output strobe_t           strobe,
  output regSel_e           rdSel
);

  logic hitCtrl, hitState, hitStrobe, hitIen, hitCause;
  logic unusedWdata;

  assign hitCtrl   = (regAddr == ADDR_W'(OFS_CTRL));
  assign hitState  = (regAddr == ADDR_W'(OFS_STATE));
  assign hitStrobe = (regAddr == ADDR_W'(OFS_STROBE));
  assign hitIen    = (regAddr == ADDR_W'(OFS_IEN));
  assign hitCause  = (regAddr == ADDR_W'(OFS_CAUSE));

  // only a subset of write data bits carries meaning
  assign unusedWdata = ^regWdata;

  always_comb begin
    if (hitCtrl)        rdSel = SEL_CTRL;
    else if (hitState)  rdSel = SEL_STATE;
    else if (hitStrobe) rdSel = SEL_STROBE;
    else if (hitIen)    rdSel = SEL_IEN;
    else if (hitCause)  rdSel = SEL_CAUSE;
    else                rdSel = SEL_NONE;
  end

  always_comb begin
    strobe = '0;
    strobe.ctrlWr          = regWr & hitCtrl;
    strobe.ctrlVal[ERR_PE]  = regWdata[CT_PE_BIT];
    strobe.ctrlVal[ERR_FE]  = regWdata[CT_FE_BIT];
    strobe.ctrlVal[ERR_ROE] = regWdata[CT_ROE_BIT];
    strobe.ienWr           = regWr & hitIen;
    strobe.ienVal          = regWdata[NUM_IEN-1:0];
    strobe.causeClr        = (regWr & hitCause) ? regWdata[NUM_CAUSE-1:0] : '0;
    if (regWr && hitStrobe) begin
      strobe.setRen          = regWdata[SB_SET_REN];
      strobe.clrRen          = regWdata[SB_CLR_REN];
      strobe.errClr[ERR_PE]  = regWdata[SB_CLR_PE];
      strobe.errClr[ERR_FE]  = regWdata[SB_CLR_FE];
      strobe.errClr[ERR_ROE] = regWdata[SB_CLR_ROE];
    end
  end

endmodule

// File: rtl/rxerr_dp.sv
module rxerr_dp
  import rxerr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strobe,
  input  regSel_e              rdSel,
  input  logic                 rxDone,
  input  logic                 rxParityErr,
  input  logic                 rxFrameErr,
  input  logic                 rxOverrun,
  input  logic                 txDone,
  input  logic                 txSpace,
  output logic [DATA_W-1:0]    rdData,
  output logic                 rxEnable,
  output logic [NUM_ERR-1:0]   errFlags,
  output logic [NUM_ERR-1:0]   chkEn,
  output logic [NUM_IEN-1:0]   ienQ,
  output logic [NUM_CAUSE-1:0] causeQ,
  output logic                 irqTx,
  output logic                 irqRx,
  output logic                 irqErr,
  output logic                 irqTxBuf
);

  logic                 accept;
  logic [NUM_ERR-1:0]   errIn;
  logic [NUM_ERR-1:0]   errSet;
  logic [NUM_CAUSE-1:0] causeSet;

  assign accept          = rxDone & rxEnable;
  assign errIn[ERR_PE]   = rxParityErr;
  assign errIn[ERR_FE]   = rxFrameErr;
  assign errIn[ERR_ROE]  = rxOverrun;

  // per-flag sticky latch, set has priority over clear
  for (genvar g = 0; g < NUM_ERR; g++) begin : g_flag
    assign errSet[g] = accept & errIn[g] & chkEn[g];
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) errFlags[g] <= 1'b0;
      else       errFlags[g] <= errSet[g] | (errFlags[g] & ~strobe.errClr[g]);
    end
  end

  assign causeSet[IRQ_TX]  = txDone;
  assign causeSet[IRQ_RX]  = accept;
  assign causeSet[IRQ_ERR] = |errSet;

  for (genvar g = 0; g < NUM_CAUSE; g++) begin : g_cause
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) causeQ[g] <= 1'b0;
      else       causeQ[g] <= causeSet[g] | (causeQ[g] & ~strobe.causeClr[g]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              rxEnable <= 1'b0;
    else if (strobe.setRen) rxEnable <= 1'b1;
    else if (strobe.clrRen) rxEnable <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              chkEn <= '0;
    else if (strobe.ctrlWr) chkEn <= strobe.ctrlVal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             ienQ <= '0;
    else if (strobe.ienWr) ienQ <= strobe.ienVal;
  end

  assign irqTx    = causeQ[IRQ_TX] & ienQ[IRQ_TX];
  assign irqRx    = causeQ[IRQ_RX] & ienQ[IRQ_RX];
  assign irqErr   = (|errFlags) & ienQ[IRQ_ERR];
  assign irqTxBuf = txSpace & ienQ[IRQ_TXBUF];

  always_comb begin
    rdData = '0;
    unique case (rdSel)
      SEL_CTRL: begin
        rdData[CT_PE_BIT]  = chkEn[ERR_PE];
        rdData[CT_FE_BIT]  = chkEn[ERR_FE];
        rdData[CT_ROE_BIT] = chkEn[ERR_ROE];
      end
      SEL_STATE: begin
        rdData[ST_REN_BIT] = rxEnable;
        rdData[ST_PE_BIT]  = errFlags[ERR_PE];
        rdData[ST_FE_BIT]  = errFlags[ERR_FE];
        rdData[ST_ROE_BIT] = errFlags[ERR_ROE];
      end
      SEL_IEN:   rdData[NUM_IEN-1:0]   = ienQ;
      SEL_CAUSE: rdData[NUM_CAUSE-1:0] = causeQ;
      default:   rdData = '0;
    endcase
  end

endmodule

// File: rtl/rxerr_status.sv
module rxerr_status
  import rxerr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              rxDone,
  input  logic              rxParityErr,
  input  logic              rxFrameErr,
  input  logic              rxOverrun,
  input  logic              txDone,
  input  logic              txSpace,
  output logic              rxEnable,
  output logic              irqTx,
  output logic              irqRx,
  output logic              irqErr,
  output logic              irqTxBuf
);

  strobe_t              strobe;
  regSel_e              rdSel;
  logic [NUM_ERR-1:0]   errFlags;
  logic [NUM_ERR-1:0]   chkEn;
  logic [NUM_IEN-1:0]   ienQ;
  logic [NUM_CAUSE-1:0] causeQ;

  rxerr_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .regWr    (regWr),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .strobe   (strobe),
    .rdSel    (rdSel)
  );

  rxerr_dp #(.DATA_W(DATA_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .rdSel       (rdSel),
    .rxDone      (rxDone),
    .rxParityErr (rxParityErr),
    .rxFrameErr  (rxFrameErr),
    .rxOverrun   (rxOverrun),
    .txDone      (txDone),
    .txSpace     (txSpace),
    .rdData      (regRdata),
    .rxEnable    (rxEnable),
    .errFlags    (errFlags),
    .chkEn       (chkEn),
    .ienQ        (ienQ),
    .causeQ      (causeQ),
    .irqTx       (irqTx),
    .irqRx       (irqRx),
    .irqErr      (irqErr),
    .irqTxBuf    (irqTxBuf)
  );

endmodule

// File: rtl/rxerr_status_chk.sv
module rxerr_status_chk
  import rxerr_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 rxDone,
  input logic                 rxParityErr,
  input logic                 rxOverrun,
  input logic                 rxEnable,
  input logic [NUM_ERR-1:0]   errFlags,
  input logic [NUM_ERR-1:0]   chkEn,
  input logic [NUM_CAUSE-1:0] causeQ,
  input strobe_t              strobe,
  input logic                 irqErr
);

  AST_PE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlags[ERR_PE]) |-> $past(rxDone && rxEnable && rxParityErr && chkEn[ERR_PE])); // R3

  AST_OFF_NO_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    (!rxEnable && errFlags == '0 && !causeQ[IRQ_RX]) |=> (errFlags == '0 && !causeQ[IRQ_RX])); // R4

  AST_REN_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setRen |=> rxEnable); // R5

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (errFlags[ERR_ROE] && !strobe.errClr[ERR_ROE]) |=> errFlags[ERR_ROE]); // R6

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (rxDone && rxEnable && rxParityErr && chkEn[ERR_PE] && strobe.errClr[ERR_PE]) |=> errFlags[ERR_PE]); // R7

  AST_ROE_WITH_CHAR: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlags[ERR_ROE]) |-> (causeQ[IRQ_RX] && $past(rxOverrun))); // R8

  AST_NO_ERR_IRQ_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    (errFlags == '0) |-> !irqErr); // R10

endmodule

bind rxerr_status rxerr_status_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .rxDone      (rxDone),
  .rxParityErr (rxParityErr),
  .rxOverrun   (rxOverrun),
  .rxEnable    (rxEnable),
  .errFlags    (errFlags),
  .chkEn       (chkEn),
  .causeQ      (causeQ),
  .strobe      (strobe),
  .irqErr      (irqErr)
);

// File: tb/rxerr_status_test.sv
module rxerr_status_test;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] A_CTRL   = 8'h00;
  localparam logic [ADDR_W-1:0] A_STATE  = 8'h04;
  localparam logic [ADDR_W-1:0] A_STROBE = 8'h08;
  localparam logic [ADDR_W-1:0] A_IEN    = 8'h0C;
  localparam logic [ADDR_W-1:0] A_CAUSE  = 8'h10;

  localparam logic [DATA_W-1:0] CHK_ALL = 32'h001A_0000;
  localparam logic [DATA_W-1:0] PE_B  = 32'h0001_0000;
  localparam logic [DATA_W-1:0] FE_B  = 32'h0002_0000;
  localparam logic [DATA_W-1:0] ROE_B = 32'h0008_0000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWr = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic [DATA_W-1:0] regWdata = '0;
  logic [DATA_W-1:0] regRdata;
  logic rxDone = 1'b0, rxParityErr = 1'b0, rxFrameErr = 1'b0, rxOverrun = 1'b0;
  logic txDone = 1'b0, txSpace = 1'b0;
  logic rxEnable, irqTx, irqRx, irqErr, irqTxBuf;

  int checkCount = 0;
  int failCount = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxerr_status #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .rxDone(rxDone),
    .rxParityErr(rxParityErr), .rxFrameErr(rxFrameErr), .rxOverrun(rxOverrun),
    .txDone(txDone), .txSpace(txSpace), .rxEnable(rxEnable), .irqTx(irqTx),
    .irqRx(irqRx), .irqErr(irqErr), .irqTxBuf(irqTxBuf)
  );

  task automatic check(input string tag, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic writeReg(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0; regWdata = '0;
  endtask

  task automatic readReg(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic rxEvent(input logic pe, input logic fe, input logic roe);
    @(negedge clk);
    rxDone = 1'b1; rxParityErr = pe; rxFrameErr = fe; rxOverrun = roe;
    @(negedge clk);
    rxDone = 1'b0; rxParityErr = 1'b0; rxFrameErr = 1'b0; rxOverrun = 1'b0;
  endtask

  task automatic testReset();
    logic [DATA_W-1:0] v;
    readReg(A_CTRL, v);  check("R1 ctrl", v, 0);
    readReg(A_STATE, v); check("R1 state", v, 0);
    readReg(A_IEN, v);   check("R1 ien", v, 0);
    readReg(A_CAUSE, v); check("R1 cause", v, 0);
    check("R1 irqs+ren", {27'd0, rxEnable, irqTx, irqRx, irqErr, irqTxBuf}, 0);
  endtask

  task automatic testDiscardWhenOff();
    logic [DATA_W-1:0] v;
    writeReg(A_CTRL, CHK_ALL | 32'h0000_00FF);
    readReg(A_CTRL, v); check("R3 ctrl readback", v, CHK_ALL);
    rxEvent(1, 1, 1);
    readReg(A_STATE, v); check("R4 no flags while off", v, 0);
    readReg(A_CAUSE, v); check("R4 no rx cause while off", v, 0);
  endtask

  task automatic testRenStrobe();
    logic [DATA_W-1:0] v;
    writeReg(A_STROBE, 32'h2);
    readReg(A_STATE, v); check("R5 set ren", v, 1);
    check("R5 rxEnable pin", {31'd0, rxEnable}, 1);
    readReg(A_STROBE, v); check("R5 strobe reads 0", v, 0);
    writeReg(A_STROBE, 32'h1);
    readReg(A_STATE, v); check("R5 clear ren", v, 0);
    writeReg(A_STROBE, 32'h3);
    readReg(A_STATE, v); check("R5 set wins over clear", v, 1);
  endtask

  task automatic testParity();
    logic [DATA_W-1:0] v;
    rxEvent(1, 0, 0);
    readReg(A_STATE, v); check("R2 parity bit 16", v, PE_B | 1);
    readReg(A_CAUSE, v); check("R9 rx+err cause", v, 32'h6);
    writeReg(A_STROBE, 32'h4);
    readReg(A_STATE, v); check("R6 clear parity", v, 1);
    readReg(A_CAUSE, v); check("R9 cause holds", v, 32'h6);
    writeReg(A_CAUSE, 32'h6);
    readReg(A_CAUSE, v); check("R9 write-1-clear", v, 0);
  endtask

  task automatic testFrameOverrun();
    logic [DATA_W-1:0] v;
    rxEvent(0, 1, 0);
    readReg(A_STATE, v); check("R2 framing bit 17", v, FE_B | 1);
    writeReg(A_CAUSE, 32'h7);
    rxEvent(0, 0, 1);
    readReg(A_STATE, v); check("R2 overrun bit 19 stacked", v, FE_B | ROE_B | 1);
    readReg(A_CAUSE, v); check("R8 overrun with character", v, 32'h6);
    writeReg(A_STATE, 32'h0);
    readReg(A_STATE, v); check("R6 state write ignored", v, FE_B | ROE_B | 1);
    writeReg(A_STROBE, 32'h4);
    readReg(A_STATE, v); check("R6 wrong clear ignored", v, FE_B | ROE_B | 1);
    writeReg(A_STROBE, 32'h8);
    readReg(A_STATE, v); check("R6 clear framing", v, ROE_B | 1);
    writeReg(A_STROBE, 32'h20);
    readReg(A_STATE, v); check("R6 clear overrun", v, 1);
    writeReg(A_CAUSE, 32'h7);
  endtask

  task automatic testCheckEnable();
    logic [DATA_W-1:0] v;
    writeReg(A_CTRL, PE_B << 4);
    readReg(A_CTRL, v); check("R3 parity-only ctrl", v, 32'h0010_0000);
    rxEvent(0, 1, 1);
    readReg(A_STATE, v); check("R3 disabled checks latch nothing", v, 1);
    readReg(A_CAUSE, v); check("R3 char still received", v, 32'h2);
    rxEvent(1, 0, 0);
    readReg(A_STATE, v); check("R3 enabled check latches", v, PE_B | 1);
    writeReg(A_STROBE, 32'h4);
    writeReg(A_CAUSE, 32'h7);
    writeReg(A_CTRL, CHK_ALL);
  endtask

  task automatic testCollisions();
    logic [DATA_W-1:0] v;
    @(negedge clk);
    rxDone = 1'b1; rxParityErr = 1'b1;
    regWr = 1'b1; regAddr = A_STROBE; regWdata = 32'h4;
    @(negedge clk);
    rxDone = 1'b0; rxParityErr = 1'b0; regWr = 1'b0; regWdata = '0;
    readReg(A_STATE, v); check("R7 set beats clear", v, PE_B | 1);
    writeReg(A_STROBE, 32'h4);
    writeReg(A_CAUSE, 32'h7);
    @(negedge clk);
    txDone = 1'b1; regWr = 1'b1; regAddr = A_CAUSE; regWdata = 32'h1;
    @(negedge clk);
    txDone = 1'b0; regWr = 1'b0; regWdata = '0;
    readReg(A_CAUSE, v); check("R9 tx event beats clear", v, 32'h1);
    writeReg(A_CAUSE, 32'h1);
  endtask

  task automatic testIrq();
    logic [DATA_W-1:0] v;
    writeReg(A_IEN, 32'hF);
    readReg(A_IEN, v); check("R10 ien readback", v, 32'hF);
    check("R10 quiet lines", {28'd0, irqTx, irqRx, irqErr, irqTxBuf}, 0);
    txSpace = 1'b1; #1;
    check("R10 txbuf line", {31'd0, irqTxBuf}, 1);
    rxEvent(0, 0, 1);
    check("R10 rx and err lines", {28'd0, irqTx, irqRx, irqErr, irqTxBuf}, 32'h7);
    writeReg(A_CAUSE, 32'h6);
    check("R10 err follows flag not cause", {28'd0, irqTx, irqRx, irqErr, irqTxBuf}, 32'h3);
    writeReg(A_IEN, 32'h0);
    check("R10 masked", {28'd0, irqTx, irqRx, irqErr, irqTxBuf}, 0);
    writeReg(A_STROBE, 32'h20);
    txSpace = 1'b0;
  endtask

  task automatic testWriteTiming();
    logic [DATA_W-1:0] v;
    @(negedge clk);
    regWr = 1'b1; regAddr = A_IEN; regWdata = 32'h5;
    #1; v = regRdata;
    check("R11 not visible during write cycle", v, 0);
    @(negedge clk);
    regWr = 1'b0; regWdata = '0;
    readReg(A_IEN, v); check("R11 visible after edge", v, 32'h5);
    writeReg(A_IEN, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failCount++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checkCount, failCount);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testDiscardWhenOff();
    testRenStrobe();
    testParity();
    testFrameOverrun();
    testCheckEnable();
    testCollisions();
    testIrq();
    testWriteTiming();
    repeat (2) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checkCount, failCount);
    $finish;
  end

endmodule